// File: doc/BRIEF.md
# Far-Return Control Sequencer

This block carries out a far procedure return for an instruction-execution pipeline. A command gives it the current privilege level, the stack pointer, the operand size, an optional 16-bit immediate and the processor mode. The block pops the return pointer and code selector from the stack through a read port. In protected mode it fetches the parsed code descriptor through a lookup port. If the privilege level changes, it also pops a new stack pointer and stack selector and fetches the stack descriptor.

The block checks privilege, type, presence and target range. It then either commits a new instruction pointer, code selector, code base, stack pointer, privilege level and data-segment nullify mask with a one-cycle `done` pulse, or it reports a single fault with a one-cycle `fault` pulse. The command, stack-read and lookup requests are valid/ready. A request stays valid with a stable address or selector until it is accepted. Only one request is outstanding at a time. Responses arrive as one-cycle valid pulses and cannot be back-pressured. `cmd_ready` is high only while the block is idle.

Top module: `rfar_seq`

## Requirements
- R1: After reset `cmd_ready` is 1, `done` and `fault` are 0, and every result output is zero.
- R2: Operand size code 0, 1 and 2 selects 2-, 4- and 8-byte pops. Each popped word is truncated to that width and zero-extended. The first pop reads address `rsp` and gives the return pointer. The second reads `rsp`+size and gives the code selector, which is taken from its low 16 bits.
- R3: When `cmd_imm_en` is 0 the immediate counts as zero, whatever `cmd_imm` holds. When it is 1 the immediate is zero-extended.
- R4: In real-style mode (`cmd_prot`=0), a return pointer above `cmd_cs_limit` faults general-protection with error 0. Otherwise the code base is the selector times 16, the stack pointer is `rsp`+2·size+imm, the privilege level is unchanged and the mask is 0.
- R5: In protected mode the new level is the code selector bits [1:0]. If it equals the current level, exactly two pops and one lookup occur. The stack pointer becomes `rsp`+2·size+imm, the code base comes from the descriptor and the mask is 0.
- R6: On a level change the third and fourth pops read `rsp`+2·size+imm and that address plus size, giving the new stack pointer and then the stack selector. The final stack pointer is the popped pointer plus imm.
- R7: With `cmd_long`=1 the target must be canonical (bits 63 down to VA_BITS-1 all equal). Otherwise it must not exceed the descriptor limit. A violation faults general-protection with error 0.
- R8: A null code selector (bits [15:2] zero) or one whose bits [1:0] are below the current level faults general-protection with the selector, and no lookup is made. A non-code descriptor also faults general-protection with the selector. So does non-conforming code with descriptor level ≠ selector level, and conforming code with descriptor level > selector level.
- R9: A code descriptor marked not present faults not-present with the code selector.
- R10: The stack selector level must equal the code selector level; this is checked before its lookup. The stack descriptor must be writable data with descriptor level equal to the new level. Each of these violations faults general-protection with the stack selector. A stack descriptor marked not present faults stack-fault with the stack selector.
- R11: Mask bit i covers ES, DS, FS and GS for i = 0, 1, 2, 3. Segment type code 0 means data, 1 non-conforming code, 2 conforming code and 3 other. On a level change, bit i is set when the segment's level is below the new level and its type is 0 or 1.
- R12: Fault kind code 1 is general-protection, 2 is not-present and 3 is stack-fault. Checks run in the order stated above, and only the first failing one is reported. A fault commits nothing. `done` and `fault` each last one cycle and never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_prot | input | 1 | 1 = protected mode, 0 = real-style mode |
| cmd_long | input | 1 | 64-bit mode target check |
| cmd_osz | input | 2 | Operand size code |
| cmd_imm_en | input | 1 | Immediate present |
| cmd_imm | input | 16 | Immediate byte count |
| cmd_cpl | input | 2 | Current privilege level |
| cmd_rsp | input | XLEN | Current stack pointer |
| cmd_cs_limit | input | 32 | Code limit for real-style mode |
| cmd_seg_dpl | input | 2*SEGS | Data-segment levels, 2 bits each |
| cmd_seg_type | input | 2*SEGS | Data-segment type codes, 2 bits each |
| mem_req_valid | output | 1 | Stack read request |
| mem_req_ready | input | 1 | Stack read accepted |
| mem_addr | output | XLEN | Stack read address |
| mem_rsp_valid | input | 1 | Stack read data valid |
| mem_rsp_data | input | XLEN | Stack read data |
| dsc_req_valid | output | 1 | Descriptor lookup request |
| dsc_req_ready | input | 1 | Lookup accepted |
| dsc_req_sel | output | 16 | Selector to look up |
| dsc_rsp_valid | input | 1 | Lookup response valid |
| dsc_present | input | 1 | Segment present |
| dsc_code | input | 1 | Descriptor is code |
| dsc_conform | input | 1 | Code is conforming |
| dsc_write | input | 1 | Data is writable |
| dsc_dpl | input | 2 | Descriptor privilege level |
| dsc_limit | input | 32 | Segment limit |
| dsc_base | input | 32 | Segment base |
| done | output | 1 | Commit pulse |
| fault | output | 1 | Fault pulse |
| fault_kind | output | 2 | Fault class code |
| fault_err | output | 16 | Fault error code |
| out_rip | output | XLEN | New instruction pointer |
| out_cs | output | 16 | New code selector |
| out_cs_base | output | XLEN | New code base |
| out_rsp | output | XLEN | New stack pointer |
| out_cpl | output | 2 | New privilege level |
| out_null_mask | output | SEGS | Data segments to nullify |

## Verification
Each response is registered on its accepting edge. An evaluation state follows, and `done` or `fault` rises on the next edge, which is two edges after the last response. The outputs hold that value until the next result. Requests are accepted in the cycle they are raised. So each pop address is checked at the falling edge just before its accepting edge, against an address the bench computes from the stack pointer, size and immediate. Results are compared at the first falling edge where a pulse is high, in command order from a queue. The pop and lookup counts of each command are checked once its result is seen.

// File: rtl/rfar_pkg.sv
package rfar_pkg;
  localparam int SEL_W = 16;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_GP   = 2'd1,
    FK_NP   = 2'd2,
    FK_SS   = 2'd3
  } fault_e;

  typedef enum logic [3:0] {
    S_IDLE, S_POP, S_POPW, S_REAL,
    S_CSEL, S_CDSC, S_CDSCW, S_CEVAL,
    S_SSEL, S_SDSC, S_SDSCW, S_SEVAL
  } state_e;

  typedef struct packed {
    logic        present;
    logic        is_code;
    logic        conform;
    logic [1:0]  dpl;
    logic [31:0] limit;
  } cdesc_t;

  typedef struct packed {
    logic        present;
    logic        is_code;
    logic        write;
    logic [1:0]  dpl;
  } sdesc_t;
endpackage

// File: rtl/rfar_code_chk.sv
module rfar_code_chk
  import rfar_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48
) (
  input  cdesc_t           desc,
  input  logic [SEL_W-1:0] sel,
  input  logic [XLEN-1:0]  target,
  input  logic             long_mode,
  output fault_e           kind,
  output logic [SEL_W-1:0] err
);
  localparam int TOP_W = XLEN - VA_BITS + 1;

  logic [TOP_W-1:0] upper;
  logic             canonical;

  assign upper     = target[XLEN-1:VA_BITS-1];
  assign canonical = (&upper) | ~(|upper);

  always_comb begin
    kind = FK_NONE;
    err  = '0;
    if (!desc.is_code) begin
      kind = FK_GP; err = sel;
    end else if (!desc.conform && desc.dpl != sel[1:0]) begin
      kind = FK_GP; err = sel;
    end else if (desc.conform && desc.dpl > sel[1:0]) begin
      kind = FK_GP; err = sel;
    end else if (!desc.present) begin
      kind = FK_NP; err = sel;
    end else if (long_mode ? !canonical : (target > XLEN'(desc.limit))) begin
      kind = FK_GP; err = '0;
    end
  end
endmodule

// File: rtl/rfar_stack_chk.sv
module rfar_stack_chk
  import rfar_pkg::*;
(
  input  sdesc_t           desc,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       new_cpl,
  output fault_e           kind,
  output logic [SEL_W-1:0] err
);
  always_comb begin
    kind = FK_NONE;
    err  = '0;
    if (desc.is_code || !desc.write) begin
      kind = FK_GP; err = sel;
    end else if (desc.dpl != new_cpl) begin
      kind = FK_GP; err = sel;
    end else if (!desc.present) begin
      kind = FK_SS; err = sel;
    end
  end
endmodule

// File: rtl/rfar_seg_null.sv
module rfar_seg_null #(
  parameter int SEGS = 4
) (
  input  logic [2*SEGS-1:0] seg_dpl,
  input  logic [2*SEGS-1:0] seg_type,
  input  logic [1:0]        new_cpl,
  output logic [SEGS-1:0]   mask
);
  for (genvar i = 0; i < SEGS; i++) begin : g_seg
    logic [1:0] lvl;
    logic [1:0] typ;
    assign lvl     = seg_dpl[2*i +: 2];
    assign typ     = seg_type[2*i +: 2];
    assign mask[i] = (lvl < new_cpl) && (typ == 2'd0 || typ == 2'd1);
  end
endmodule

// File: rtl/rfar_seq.sv
module rfar_seq
  import rfar_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48,
  parameter int SEGS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_prot,
  input  logic              cmd_long,
  input  logic [1:0]        cmd_osz,
  input  logic              cmd_imm_en,
  input  logic [15:0]       cmd_imm,
  input  logic [1:0]        cmd_cpl,
  input  logic [XLEN-1:0]   cmd_rsp,
  input  logic [31:0]       cmd_cs_limit,
  input  logic [2*SEGS-1:0] cmd_seg_dpl,
  input  logic [2*SEGS-1:0] cmd_seg_type,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              dsc_req_valid,
  input  logic              dsc_req_ready,
  output logic [15:0]       dsc_req_sel,
  input  logic              dsc_rsp_valid,
  input  logic              dsc_present,
  input  logic              dsc_code,
  input  logic              dsc_conform,
  input  logic              dsc_write,
  input  logic [1:0]        dsc_dpl,
  input  logic [31:0]       dsc_limit,
  input  logic [31:0]       dsc_base,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_kind,
  output logic [15:0]       fault_err,
  output logic [XLEN-1:0]   out_rip,
  output logic [15:0]       out_cs,
  output logic [XLEN-1:0]   out_cs_base,
  output logic [XLEN-1:0]   out_rsp,
  output logic [1:0]        out_cpl,
  output logic [SEGS-1:0]   out_null_mask
);
  localparam int SW = 2 * SEGS;

  function automatic logic [XLEN-1:0] f_size(input logic [1:0] osz);
    case (osz)
      2'd0:    return XLEN'(2);
      2'd1:    return XLEN'(4);
      default: return XLEN'(8);
    endcase
  endfunction

  function automatic logic [XLEN-1:0] f_mask(input logic [1:0] osz);
    case (osz)
      2'd0:    return XLEN'(16'hFFFF);
      2'd1:    return XLEN'(32'hFFFF_FFFF);
      default: return '1;
    endcase
  endfunction

  state_e           st;
  logic [1:0]       pidx;
  logic [XLEN-1:0]  sp;
  logic             r_prot, r_long;
  logic [1:0]       r_osz, r_cpl;
  logic [XLEN-1:0]  r_imm;
  logic [31:0]      r_lim;
  logic [SW-1:0]    r_sdpl, r_styp;
  logic [XLEN-1:0]  t_rip, t_rsp;
  logic [SEL_W-1:0] t_cs, t_ss;
  cdesc_t           c_desc;
  logic [31:0]      c_base;
  sdesc_t           s_desc;
  logic [XLEN-1:0]  pdata;

  fault_e           code_kind, stk_kind, chk_kind, fkind_q;
  logic [SEL_W-1:0] code_err, stk_err, chk_err;
  logic [SEGS-1:0]  seg_mask;

  assign pdata = mem_rsp_data & f_mask(r_osz);

  rfar_code_chk #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_code_chk (
    .desc(c_desc), .sel(t_cs), .target(t_rip), .long_mode(r_long),
    .kind(code_kind), .err(code_err)
  );

  rfar_stack_chk u_stack_chk (
    .desc(s_desc), .sel(t_ss), .new_cpl(t_cs[1:0]),
    .kind(stk_kind), .err(stk_err)
  );

  rfar_seg_null #(.SEGS(SEGS)) u_seg_null (
    .seg_dpl(r_sdpl), .seg_type(r_styp), .new_cpl(t_cs[1:0]), .mask(seg_mask)
  );

  // Check selected by the current evaluation state; none elsewhere.
  always_comb begin
    chk_kind = FK_NONE;
    chk_err  = '0;
    unique case (st)
      S_REAL:  if (t_rip > XLEN'(r_lim)) chk_kind = FK_GP;
      S_CSEL:  if (t_cs[15:2] == '0 || t_cs[1:0] < r_cpl) begin
                 chk_kind = FK_GP; chk_err = t_cs;
               end
      S_CEVAL: begin chk_kind = code_kind; chk_err = code_err; end
      S_SSEL:  if (t_ss[1:0] != t_cs[1:0]) begin
                 chk_kind = FK_GP; chk_err = t_ss;
               end
      S_SEVAL: begin chk_kind = stk_kind; chk_err = stk_err; end
      default: ;
    endcase
  end

  assign cmd_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_POP);
  assign mem_addr      = sp;
  assign dsc_req_valid = (st == S_CDSC) || (st == S_SDSC);
  assign dsc_req_sel   = (st == S_SDSC) ? t_ss : t_cs;
  assign fault_kind    = fkind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pidx <= '0; sp <= '0;
      r_prot <= 1'b0; r_long <= 1'b0; r_osz <= '0; r_cpl <= '0;
      r_imm <= '0; r_lim <= '0; r_sdpl <= '0; r_styp <= '0;
      t_rip <= '0; t_rsp <= '0; t_cs <= '0; t_ss <= '0;
      c_desc <= '0; c_base <= '0; s_desc <= '0;
      done <= 1'b0; fault <= 1'b0; fkind_q <= FK_NONE; fault_err <= '0;
      out_rip <= '0; out_cs <= '0; out_cs_base <= '0; out_rsp <= '0;
      out_cpl <= '0; out_null_mask <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (chk_kind != FK_NONE) begin
        fault     <= 1'b1;
        fkind_q   <= chk_kind;
        fault_err <= chk_err;
        st        <= S_IDLE;
      end else begin
        unique case (st)
          S_IDLE: if (cmd_valid) begin
            r_prot <= cmd_prot; r_long <= cmd_long; r_osz <= cmd_osz;
            r_cpl  <= cmd_cpl;  r_lim  <= cmd_cs_limit;
            r_imm  <= cmd_imm_en ? XLEN'(cmd_imm) : '0;
            r_sdpl <= cmd_seg_dpl; r_styp <= cmd_seg_type;
            sp <= cmd_rsp; pidx <= '0; st <= S_POP;
          end
          S_POP: if (mem_req_ready) st <= S_POPW;
          S_POPW: if (mem_rsp_valid) begin
            pidx <= pidx + 2'd1;
            unique case (pidx)
              2'd0: begin t_rip <= pdata; sp <= sp + f_size(r_osz); st <= S_POP; end
              2'd1: begin
                t_cs <= pdata[SEL_W-1:0];
                sp   <= sp + f_size(r_osz) + r_imm;
                st   <= r_prot ? S_CSEL : S_REAL;
              end
              2'd2: begin t_rsp <= pdata; sp <= sp + f_size(r_osz); st <= S_POP; end
              default: begin t_ss <= pdata[SEL_W-1:0]; st <= S_SSEL; end
            endcase
          end
          S_REAL: begin
            out_rip <= t_rip; out_cs <= t_cs;
            out_cs_base <= XLEN'({t_cs, 4'b0000});
            out_rsp <= sp; out_cpl <= r_cpl; out_null_mask <= '0;
            done <= 1'b1; st <= S_IDLE;
          end
          S_CSEL: st <= S_CDSC;
          S_CDSC: if (dsc_req_ready) st <= S_CDSCW;
          S_CDSCW: if (dsc_rsp_valid) begin
            c_desc <= '{present: dsc_present, is_code: dsc_code,
                        conform: dsc_conform, dpl: dsc_dpl, limit: dsc_limit};
            c_base <= dsc_base;
            st <= S_CEVAL;
          end
          S_CEVAL: begin
            if (t_cs[1:0] == r_cpl) begin
              out_rip <= t_rip; out_cs <= t_cs; out_cs_base <= XLEN'(c_base);
              out_rsp <= sp; out_cpl <= r_cpl; out_null_mask <= '0;
              done <= 1'b1; st <= S_IDLE;
            end else begin
              st <= S_POP;
            end
          end
          S_SSEL: st <= S_SDSC;
          S_SDSC: if (dsc_req_ready) st <= S_SDSCW;
          S_SDSCW: if (dsc_rsp_valid) begin
            s_desc <= '{present: dsc_present, is_code: dsc_code,
                        write: dsc_write, dpl: dsc_dpl};
            st <= S_SEVAL;
          end
          S_SEVAL: begin
            out_rip <= t_rip; out_cs <= t_cs; out_cs_base <= XLEN'(c_base);
            out_rsp <= t_rsp + r_imm; out_cpl <= t_cs[1:0];
            out_null_mask <= seg_mask;
            done <= 1'b1; st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rfar_seq_check.sv
module rfar_seq_check #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done,
  input logic            fault,
  input logic [1:0]      fault_kind,
  input logic [XLEN-1:0] out_rip,
  input logic [XLEN-1:0] out_rsp,
  input logic [1:0]      out_cpl,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_addr,
  input logic            dsc_req_valid,
  input logic            dsc_req_ready,
  input logic [15:0]     dsc_req_sel
);
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);
  a_r12_fault_class: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> fault_kind != 2'd0);
  a_r12_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($stable(out_rip) && $stable(out_rsp) && $stable(out_cpl)));
  a_r2_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));
  a_r8_lookup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_req_valid && !dsc_req_ready) |=> (dsc_req_valid && $stable(dsc_req_sel)));
endmodule

bind rfar_seq rfar_seq_check #(.XLEN(XLEN)) u_chk (.*);

// File: tb/rfar_seq_bench.sv
`timescale 1ns/1ps
module rfar_seq_bench;
  typedef struct packed {
    logic p, c, cf, wr;
    logic [1:0] dpl;
    logic [31:0] lim, base;
  } bdesc_t;

  typedef struct {
    logic flt;
    logic [1:0] kind;
    logic [15:0] err;
    logic [63:0] rip, base, rsp;
    logic [15:0] cs;
    logic [1:0] cpl;
    logic [3:0] mask;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_prot = 1'b0, cmd_long = 1'b0, cmd_imm_en = 1'b0;
  logic [1:0] cmd_osz = '0, cmd_cpl = '0;
  logic [15:0] cmd_imm = '0;
  logic [63:0] cmd_rsp = '0;
  logic [31:0] cmd_cs_limit = '0;
  logic [7:0] cmd_seg_dpl = '0, cmd_seg_type = '0;
  logic cmd_ready, mem_req_valid, dsc_req_valid, done, fault;
  logic mem_req_ready = 1'b1, dsc_req_ready = 1'b1;
  logic mem_rsp_valid = 1'b0, dsc_rsp_valid = 1'b0;
  logic [63:0] mem_addr, mem_rsp_data = '0;
  logic [15:0] dsc_req_sel, fault_err, out_cs;
  logic dsc_present = 0, dsc_code = 0, dsc_conform = 0, dsc_write = 0;
  logic [1:0] dsc_dpl = '0, fault_kind, out_cpl;
  logic [31:0] dsc_limit = '0, dsc_base = '0;
  logic [63:0] out_rip, out_cs_base, out_rsp;
  logic [3:0] out_null_mask;

  rfar_seq u_rfar_seq (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0, n_res = 0, pops = 0, looks = 0;
  logic [63:0] w [4];
  logic [63:0] exp_addr [4];
  bdesc_t cdesc, sdesc;
  exp_t q [$];
  logic [63:0] last_rip = '0, last_rsp = '0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // stack read responder (R2, R6 addresses)
  initial forever begin
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    if (mem_req_valid) begin
      chk("R2/R6", mem_addr, exp_addr[pops & 3], "pop address");
      @(negedge clk);
      mem_rsp_data  = w[pops & 3];
      mem_rsp_valid = 1'b1;
      pops++;
    end
  end

  // descriptor responder: code first, stack second
  initial forever begin
    bdesc_t d;
    @(negedge clk);
    dsc_rsp_valid = 1'b0;
    if (dsc_req_valid) begin
      d = (looks == 0) ? cdesc : sdesc;
      @(negedge clk);
      {dsc_present, dsc_code, dsc_conform, dsc_write} = {d.p, d.c, d.cf, d.wr};
      dsc_dpl = d.dpl; dsc_limit = d.lim; dsc_base = d.base;
      dsc_rsp_valid = 1'b1;
      looks++;
    end
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (done || fault) begin
      if (q.size() == 0) begin
        chk("R12", 1, 0, "unexpected result pulse");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, fault, e.flt, "fault vs commit");
        if (!e.flt) begin
          chk(e.tag, out_rip, e.rip, "rip");
          chk(e.tag, out_cs, e.cs, "cs");
          chk(e.tag, out_cs_base, e.base, "code base");
          chk(e.tag, out_rsp, e.rsp, "rsp");
          chk(e.tag, out_cpl, e.cpl, "cpl");
          chk(e.tag, out_null_mask, e.mask, "nullify mask");
          last_rip = e.rip; last_rsp = e.rsp;
        end else begin
          chk(e.tag, fault_kind, e.kind, "fault kind");
          chk(e.tag, fault_err, e.err, "fault error");
          chk("R12", out_rip, last_rip, "rip kept on fault");
          chk("R12", out_rsp, last_rsp, "rsp kept on fault");
        end
      end
      n_res++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  function automatic exp_t ok(logic [63:0] rip, logic [15:0] cs, logic [63:0] base,
                              logic [63:0] rsp, logic [1:0] cpl, logic [3:0] mask, string tag);
    exp_t e;
    e.flt = 0; e.kind = 0; e.err = 0; e.rip = rip; e.cs = cs; e.base = base;
    e.rsp = rsp; e.cpl = cpl; e.mask = mask; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t fl(logic [1:0] kind, logic [15:0] err, string tag);
    exp_t e;
    e.flt = 1; e.kind = kind; e.err = err; e.rip = 0; e.cs = 0; e.base = 0;
    e.rsp = 0; e.cpl = 0; e.mask = 0; e.tag = tag;
    return e;
  endfunction

  task automatic setc(bit prot, bit lng, logic [1:0] osz, bit ie, logic [15:0] imm,
                      logic [1:0] cpl, logic [63:0] rsp, logic [31:0] lim);
    cmd_prot = prot; cmd_long = lng; cmd_osz = osz; cmd_imm_en = ie; cmd_imm = imm;
    cmd_cpl = cpl; cmd_rsp = rsp; cmd_cs_limit = lim;
  endtask

  function automatic bdesc_t mkd(bit p, bit c, bit cf, bit wr, logic [1:0] dpl,
                                 logic [31:0] lim, logic [31:0] base);
    bdesc_t d;
    d.p = p; d.c = c; d.cf = cf; d.wr = wr; d.dpl = dpl; d.lim = lim; d.base = base;
    return d;
  endfunction

  task automatic go(exp_t e, int np, int nl);
    logic [63:0] sz, iv;
    int tgt;
    sz = (cmd_osz == 0) ? 64'd2 : (cmd_osz == 1) ? 64'd4 : 64'd8;
    iv = cmd_imm_en ? {48'd0, cmd_imm} : 64'd0;
    exp_addr[0] = cmd_rsp;
    exp_addr[1] = cmd_rsp + sz;
    exp_addr[2] = cmd_rsp + 2 * sz + iv;
    exp_addr[3] = exp_addr[2] + sz;
    pops = 0; looks = 0;
    q.push_back(e);
    tgt = n_res + 1;
    @(negedge clk);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait (n_res == tgt);
    @(negedge clk);
    chk(e.tag, pops, np, "pop count");
    chk(e.tag, looks, nl, "lookup count");
  endtask

  localparam logic [63:0] LA = 64'hFFFF_8000_0000_1000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", cmd_ready, 1, "cmd_ready");
    chk("R1", {done, fault}, 0, "pulses");
    chk("R1", out_rsp | out_rip | out_cs_base, 0, "result regs");
    chk("R1", {out_cs, out_cpl, out_null_mask}, 0, "result fields");

    // R4 R3: real mode, 16-bit, immediate disabled but non-zero value
    w[0] = 64'hABCD_1234; w[1] = 64'h9_2000;
    setc(0, 0, 0, 0, 16'h55, 0, 64'h100, 32'hFFFF);
    go(ok(64'h1234, 16'h2000, 64'h20000, 64'h104, 0, 0, "R4 R3"), 2, 0);
    // R2 R3: 32-bit truncation and immediate
    w[0] = 64'hDEAD_0000_0000_1000; w[1] = 64'h1_0000_0040;
    setc(0, 0, 1, 1, 16'h6, 0, 64'h200, 32'hFFFF_FFFF);
    go(ok(64'h1000, 16'h0040, 64'h400, 64'h20E, 0, 0, "R2 R3"), 2, 0);
    // R4: limit violation
    w[0] = 64'h9000; w[1] = 64'h10;
    setc(0, 0, 0, 0, 0, 0, 64'h300, 32'h8FFF);
    go(fl(1, 0, "R4 limit"), 2, 0);

    // R5: same level, 64-bit
    w[0] = LA; w[1] = 64'h1B;
    cdesc = mkd(1, 1, 0, 0, 3, 0, 0);
    setc(1, 1, 2, 1, 16'h10, 3, 64'h1000, 0);
    go(ok(LA, 16'h1B, 0, 64'h1020, 3, 0, "R5"), 2, 1);
    // R8: conforming code, descriptor level below selector level passes
    cdesc = mkd(1, 1, 1, 0, 0, 0, 32'h40);
    go(ok(LA, 16'h1B, 64'h40, 64'h1020, 3, 0, "R8 conform ok"), 2, 1);

    // R6 R11: level change 0 -> 3
    w[0] = 64'h4000; w[1] = 64'h33; w[2] = 64'h7000; w[3] = 64'h2B;
    cdesc = mkd(1, 1, 0, 0, 3, 0, 0);
    sdesc = mkd(1, 0, 0, 1, 3, 0, 0);
    cmd_seg_dpl = 8'h00; cmd_seg_type = 8'hE4;
    setc(1, 1, 2, 1, 16'h8, 0, 64'h500, 0);
    go(ok(64'h4000, 16'h33, 0, 64'h7008, 3, 4'h3, "R6 R11"), 4, 2);
    // R6 R11 R7: 32-bit, non-long, ES level not below
    w[0] = 64'h2000; w[2] = 64'h9_0000_1111;
    cdesc = mkd(1, 1, 0, 0, 3, 32'hFFFF, 32'h1000);
    cmd_seg_dpl = 8'h03; cmd_seg_type = 8'h00;
    setc(1, 0, 1, 0, 0, 1, 64'h800, 0);
    go(ok(64'h2000, 16'h33, 64'h1000, 64'h1111, 3, 4'hE, "R6 R11 mask"), 4, 2);

    // R7: non-canonical target in long mode
    w[0] = 64'h0000_8000_0000_0000; w[1] = 64'h1B;
    cdesc = mkd(1, 1, 0, 0, 3, 0, 0);
    setc(1, 1, 2, 0, 0, 3, 64'h1000, 0);
    go(fl(1, 0, "R7 canonical"), 2, 1);
    // R7: limit in non-long protected mode
    w[0] = 64'h1_0000;
    cdesc = mkd(1, 1, 0, 0, 3, 32'hFFFF, 0);
    setc(1, 0, 1, 0, 0, 3, 64'h1000, 0);
    go(fl(1, 0, "R7 limit"), 2, 1);

    // R8: selector checks before lookup
    w[0] = 64'h10; w[1] = 64'h0003;
    setc(1, 1, 2, 0, 0, 3, 64'h1000, 0);
    go(fl(1, 16'h0003, "R8 null"), 2, 0);
    w[1] = 64'h0010;
    go(fl(1, 16'h0010, "R8 rpl below cpl"), 2, 0);
    // R8: descriptor type and level checks
    w[1] = 64'h1B;
    cdesc = mkd(1, 0, 0, 1, 3, 0, 0);
    go(fl(1, 16'h1B, "R8 not code"), 2, 1);
    cdesc = mkd(1, 1, 0, 0, 2, 0, 0);
    go(fl(1, 16'h1B, "R8 nonconform dpl"), 2, 1);
    w[1] = 64'h19;
    cdesc = mkd(1, 1, 1, 0, 2, 0, 0);
    setc(1, 1, 2, 0, 0, 1, 64'h1000, 0);
    go(fl(1, 16'h19, "R8 conform dpl"), 2, 1);
    // R9: not present
    w[1] = 64'h1B;
    cdesc = mkd(0, 1, 0, 0, 3, 0, 0);
    setc(1, 1, 2, 0, 0, 3, 64'h1000, 0);
    go(fl(2, 16'h1B, "R9"), 2, 1);
    // R12: non-code and not present, first check wins
    cdesc = mkd(0, 0, 0, 0, 3, 0, 0);
    go(fl(1, 16'h1B, "R12 priority"), 2, 1);

    // R10: stack checks on level change
    w[0] = 64'h4000; w[1] = 64'h33; w[2] = 64'h7000; w[3] = 64'h28;
    cdesc = mkd(1, 1, 0, 0, 3, 0, 0);
    sdesc = mkd(1, 0, 0, 1, 3, 0, 0);
    setc(1, 1, 2, 0, 0, 0, 64'h500, 0);
    go(fl(1, 16'h28, "R10 ss rpl"), 4, 1);
    w[3] = 64'h2B;
    sdesc = mkd(1, 0, 0, 0, 3, 0, 0);
    go(fl(1, 16'h2B, "R10 not writable"), 4, 2);
    sdesc = mkd(1, 0, 0, 1, 2, 0, 0);
    go(fl(1, 16'h2B, "R10 dpl"), 4, 2);
    sdesc = mkd(0, 0, 0, 1, 3, 0, 0);
    go(fl(3, 16'h2B, "R10 not present"), 4, 2);

    repeat (4) @(negedge clk);
    chk("R12", q.size(), 0, "results outstanding");
    finish_run();
  end
endmodule